// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

An 8-bit up-counter that counts input ticks through a selectable prescaler. It restarts from zero when its value equals a programmable period register. Each equality produces a one-cycle match strobe, which can also serve as the shift-clock strobe of a serial peripheral. Match events pass through a programmable postscaler, and this postscaler sets a sticky interrupt flag that a write-one-to-clear input resets.

A small register bus reaches the count, period and control registers. Register address 0 is the count, address 1 the period, address 2 the control and address 3 unused. A write takes effect at the clock edge. Read data is combinational from the address. The control register holds the postscale selection in bits 6:3, the enable in bit 2 and the prescale selection in bits 1:0. Bit 7 of the control register is not stored.

Top module: `pm_timer`

## Requirements
- R1: While enabled, the count register (address 0) increments by one on each prescaled tick, starting from 0x00 after reset.
- R2: Control bits 1:0 select the prescale: 00 gives one prescaled tick per `tick_en` pulse, 01 gives one per 4 pulses, 10 and 11 give one per 16 pulses.
- R3: On a prescaled tick where the count equals the period, `match_stb` is high for that cycle and the count reads 0x00 on the next cycle.
- R4: With control bits 6:3 set to n, the interrupt flag is set once for every n+1 matches, so the flag is raised on the (n+1)th match.
- R5: After reset the count reads 0x00, the period reads 0xFF, the control reads 0x00 and `irq` is low.
- R6: A write to address 0 or address 2 clears both the prescaler and the postscaler progress. Any tick in that same cycle is discarded.
- R7: A write to the control register leaves the count unchanged.
- R8: The control register reads back bits 6:0 as written, and bit 7 always reads 0.
- R9: With control bit 2 low, the count holds, `tick_en` has no effect and `match_stb` stays low.
- R10: `irq` stays high until `irq_clr` is pulsed. If a postscaler event arrives in the same cycle as `irq_clr`, `irq` stays set.
- R11: A write to the count register loads the written value and takes priority over a tick in the same cycle. Counting continues from the loaded value.
- R12: The period register (address 1) reads back what was written, and a period write does not disturb the divider progress. Address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count tick, one cycle per input tick |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 count, 1 period, 2 control, 3 none) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| irq_clr | input | 1 | Clears the interrupt flag |
| irq | output | 1 | Sticky interrupt flag |
| match_stb | output | 1 | One-cycle strobe on each period match |

## Verification
The assertions assume that reset is held for at least one clock edge before any check applies. They also assume that the bus address is always a defined 2-bit value. They place no limit on how often writes, ticks or clears arrive. The stimulus therefore mixes writes to every address, including address 3, with ticks and clears in any combination, even in the same cycle. Period values are drawn mostly small so that matches, wraps and postscaler events occur often within the run.

// File: rtl/pm_timer_pkg.sv
package pm_timer_pkg;

  localparam int PRE_W  = 4;
  localparam int POST_W = 4;

  typedef enum logic [1:0] {
    REG_COUNT  = 2'd0,
    REG_PERIOD = 2'd1,
    REG_CTRL   = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [POST_W-1:0] post;
    logic              en;
    logic [1:0]        pre;
  } ctrl_t;

  // last prescaler state before a prescaled tick fires
  function automatic logic [PRE_W-1:0] presc_last(input logic [1:0] sel);
    logic [PRE_W-1:0] r;
    case (sel)
      2'b00:   r = PRE_W'(0);
      2'b01:   r = PRE_W'(3);
      default: r = PRE_W'(15);
    endcase
    return r;
  endfunction

  // wrapping increment of a counter value
  function automatic logic [7:0] bump8(input logic [7:0] v);
    return v + 8'd1;
  endfunction

endpackage

// File: rtl/pm_prescaler.sv
module pm_prescaler
  import pm_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       step_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] last;
  logic             at_last;

  assign last    = presc_last(sel_i);
  assign at_last = (cnt_q == last);
  assign tick_o  = step_i && !clr_i && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (step_i)  cnt_q <= at_last ? '0 : cnt_q + PRE_W'(1);
  end

  assert_pre_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

  assert_pre_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/pm_counter.sv
module pm_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] count_o,
  output logic         match_o
);

  logic [W-1:0] cnt_q;
  logic         equal;

  assign equal   = (cnt_q == period_i);
  assign match_o = adv_i && !load_i && equal;
  assign count_o = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (adv_i)  cnt_q <= equal ? '0 : cnt_q + W'(1);
  end

  assert_wrap_after_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |=> (cnt_q == '0));

  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && !match_o) |=> (cnt_q == W'($past(cnt_q) + W'(1))));

  assert_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i)));

endmodule

// File: rtl/pm_postscaler.sv
module pm_postscaler
  import pm_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              match_i,
  input  logic [POST_W-1:0] sel_i,
  output logic              event_o
);

  logic [POST_W-1:0] cnt_q;
  logic              at_sel;

  assign at_sel  = (cnt_q == sel_i);
  assign event_o = match_i && !clr_i && at_sel;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (match_i)  cnt_q <= at_sel ? '0 : cnt_q + POST_W'(1);
  end

  assert_event_on_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |-> match_i);

  assert_post_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/pm_timer.sv
module pm_timer
  import pm_timer_pkg::*;
#(
  parameter int              CNT_W      = 8,
  parameter logic [CNT_W-1:0] PERIOD_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             irq_clr,
  output logic             irq,
  output logic             match_stb
);

  localparam int CTRL_W = $bits(ctrl_t);

  reg_sel_e         sel;
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] count;
  logic             wr_count, wr_period, wr_ctrl, chain_clr;
  logic             step, pre_tick, match, post_evt;
  logic             irq_q;

  assign sel       = reg_sel_e'(bus_addr);
  assign wr_count  = bus_wr && (sel == REG_COUNT);
  assign wr_period = bus_wr && (sel == REG_PERIOD);
  assign wr_ctrl   = bus_wr && (sel == REG_CTRL);
  assign chain_clr = wr_count || wr_ctrl;
  assign step      = tick_en && ctrl_q.en;

  pm_prescaler u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (chain_clr),
    .step_i (step),
    .sel_i  (ctrl_q.pre),
    .tick_o (pre_tick)
  );

  pm_counter #(.W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_i      (pre_tick),
    .load_i     (wr_count),
    .load_val_i (bus_wdata),
    .period_i   (period_q),
    .count_o    (count),
    .match_o    (match)
  );

  pm_postscaler u_post (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (chain_clr),
    .match_i (match),
    .sel_i   (ctrl_q.post),
    .event_o (post_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      period_q <= PERIOD_RST;
    end else begin
      if (wr_ctrl)   ctrl_q   <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (wr_period) period_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        irq_q <= 1'b0;
    else if (post_evt) irq_q <= 1'b1;
    else if (irq_clr)  irq_q <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    case (sel)
      REG_COUNT:  bus_rdata = count;
      REG_PERIOD: bus_rdata = period_q;
      REG_CTRL:   bus_rdata = CNT_W'(ctrl_q);
      default:    bus_rdata = '0;
    endcase
  end

  assign irq       = irq_q;
  assign match_stb = match;

  assert_strobe_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    match_stb |-> ctrl_q.en);

  assert_hold_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.en && !wr_count) |=> $stable(count));

  assert_ctrl_keeps_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (count == $past(count)));

  assert_irq_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    post_evt |=> irq);

  assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  assert_period_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_period |=> (period_q == $past(bus_wdata)));

endmodule

// File: tb/test_pm_timer.sv
module test_pm_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq_clr = 1'b0;
  logic       irq;
  logic       match_stb;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference state
  logic [7:0] m_cnt, m_per;
  logic [6:0] m_ctrl;
  int         m_pc, m_ps;
  logic       m_irq;

  logic [7:0] obs_rdata;
  logic       obs_irq, obs_match;

  always #4 clk = ~clk;

  pm_timer i_pm_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_clr(irq_clr), .irq(irq), .match_stb(match_stb)
  );

  function automatic int div_of(input logic [1:0] p);
    if (p[1]) return 16;
    if (p[0]) return 4;
    return 1;
  endfunction

  function automatic logic [7:0] rd_model(input logic [1:0] a);
    case (a)
      2'd0: return m_cnt;
      2'd1: return m_per;
      2'd2: return {1'b0, m_ctrl};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] a);
    case (a)
      2'd0: return "R1";
      2'd1: return "R12";
      2'd2: return "R8";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic step(input bit tk, input bit wr, input logic [1:0] a,
                      input logic [7:0] d, input bit clr);
    bit         en, wc, wk, cl, ptick, em, ev;
    int         dv;
    logic [7:0] n_cnt;
    @(negedge clk);
    tick_en = tk; bus_wr = wr; bus_addr = a; bus_wdata = d; irq_clr = clr;
    #1;
    en = m_ctrl[2];
    wc = wr && a == 2'd0;
    wk = wr && a == 2'd2;
    cl = wc || wk;
    dv = div_of(m_ctrl[1:0]);
    ptick = tk && en && !cl && (m_pc + 1 == dv);
    em = ptick && (m_cnt == m_per);
    ev = em && (m_ps + 1 == int'(m_ctrl[6:3]) + 1);
    obs_rdata = bus_rdata; obs_irq = irq; obs_match = match_stb;
    chk({7'd0, match_stb}, {7'd0, em}, "R3");
    chk({7'd0, irq}, {7'd0, m_irq}, "R10");
    chk(bus_rdata, rd_model(a), tag_of(a));
    @(posedge clk);
    n_cnt = m_cnt;
    if (wc) n_cnt = d;
    else if (ptick) n_cnt = em ? 8'd0 : m_cnt + 8'd1;
    if (cl) m_pc = 0;
    else if (tk && en) m_pc = (m_pc + 1 == dv) ? 0 : m_pc + 1;
    if (cl) m_ps = 0;
    else if (em) m_ps = ev ? 0 : m_ps + 1;
    if (ev) m_irq = 1'b1;
    else if (clr) m_irq = 1'b0;
    m_cnt = n_cnt;
    if (wr && a == 2'd1) m_per = d;
    if (wk) m_ctrl = d[6:0];
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    step(1'b0, 1'b1, a, d, 1'b0);
  endtask

  task automatic rd(input logic [1:0] a);
    step(1'b0, 1'b0, a, 8'h00, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 2'd3, 8'h00, 1'b0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd5150));
    m_cnt = 8'h00; m_per = 8'hFF; m_ctrl = 7'h00;
    m_pc = 0; m_ps = 0; m_irq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R5 reset values
    rd(2'd0); chk(obs_rdata, 8'h00, "R5");
    rd(2'd1); chk(obs_rdata, 8'hFF, "R5");
    rd(2'd2); chk(obs_rdata, 8'h00, "R5");
    chk({7'd0, obs_irq}, 8'h00, "R5");

    // R1 counting at divide-by-1
    wr(2'd2, 8'h04); wr(2'd0, 8'h00); ticks(5);
    rd(2'd0); chk(obs_rdata, 8'h05, "R1");

    // R2 prescale options
    wr(2'd2, 8'h05); wr(2'd0, 8'h00); ticks(8);
    rd(2'd0); chk(obs_rdata, 8'h02, "R2");
    wr(2'd2, 8'h06); wr(2'd0, 8'h00); ticks(32);
    rd(2'd0); chk(obs_rdata, 8'h02, "R2");
    wr(2'd2, 8'h07); wr(2'd0, 8'h00); ticks(16);
    rd(2'd0); chk(obs_rdata, 8'h01, "R2");

    // R6 count write clears prescaler progress
    wr(2'd2, 8'h05); ticks(3); wr(2'd0, 8'h10); ticks(3);
    rd(2'd0); chk(obs_rdata, 8'h10, "R6");
    ticks(1); rd(2'd0); chk(obs_rdata, 8'h11, "R6");

    // R7 control write keeps count
    wr(2'd0, 8'h35); wr(2'd2, 8'h05);
    rd(2'd0); chk(obs_rdata, 8'h35, "R7");

    // R9 disabled timer ignores ticks
    wr(2'd0, 8'h22); wr(2'd2, 8'h01);
    for (int i = 0; i < 10; i++) begin
      step(1'b1, 1'b0, 2'd0, 8'h00, 1'b0);
      chk({7'd0, obs_match}, 8'h00, "R9");
    end
    rd(2'd0); chk(obs_rdata, 8'h22, "R9");

    // R11 load wins over a simultaneous tick
    wr(2'd2, 8'h04);
    step(1'b1, 1'b1, 2'd0, 8'h40, 1'b0);
    rd(2'd0); chk(obs_rdata, 8'h40, "R11");
    ticks(1); rd(2'd0); chk(obs_rdata, 8'h41, "R11");

    // R3 match and wrap
    wr(2'd1, 8'h03); wr(2'd0, 8'h00); ticks(3);
    step(1'b1, 1'b0, 2'd0, 8'h00, 1'b0);
    chk(obs_rdata, 8'h03, "R3"); chk({7'd0, obs_match}, 8'h01, "R3");
    rd(2'd0); chk(obs_rdata, 8'h00, "R3");

    // R4 postscale 1:3 with period 1
    step(1'b0, 1'b0, 2'd0, 8'h00, 1'b1);
    wr(2'd1, 8'h01); wr(2'd2, 8'h14); wr(2'd0, 8'h00);
    ticks(5); rd(2'd3); chk({7'd0, obs_irq}, 8'h00, "R4");
    ticks(1); rd(2'd3); chk({7'd0, obs_irq}, 8'h01, "R4");

    // R10 clear, then set wins over clear
    step(1'b0, 1'b0, 2'd3, 8'h00, 1'b1);
    rd(2'd3); chk({7'd0, obs_irq}, 8'h00, "R10");
    wr(2'd1, 8'h00); wr(2'd2, 8'h04); wr(2'd0, 8'h00);
    step(1'b1, 1'b0, 2'd3, 8'h00, 1'b1);
    rd(2'd3); chk({7'd0, obs_irq}, 8'h01, "R10");

    // R8 control bit 7 not stored; R12 period and unused address
    wr(2'd2, 8'hFF); rd(2'd2); chk(obs_rdata, 8'h7F, "R8");
    rd(2'd3); chk(obs_rdata, 8'h00, "R12");
    wr(2'd1, 8'h5A); rd(2'd1); chk(obs_rdata, 8'h5A, "R12");

    // random phase, checked each cycle against the reference
    for (int i = 0; i < 4000; i++) begin
      bit         tk, w, c;
      logic [1:0] a;
      logic [7:0] d;
      tk = ($urandom % 4) != 0;
      w  = ($urandom % 16) == 0;
      c  = ($urandom % 24) == 0;
      a  = 2'($urandom % 4);
      d  = 8'($urandom);
      if (w && a == 2'd1) d = 8'($urandom % 8);
      if (w && a == 2'd2 && ($urandom % 4) != 0) d[2] = 1'b1;
      if (w && a == 2'd2) d[6:3] = 4'($urandom % 4);
      step(tk, w, a, d, c);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule